// File: doc/BRIEF.md
# Sampling ADC Serial Capture Controller

This block is the host end of a link to a 16-bit successive-approximation converter with a serial output. The host drives three lines to the converter: a sample-control line (`sample_o`), a conversion clock (`cclk_o`) and a calibration line (`cal_o`). The converter returns a busy flag and a serial data line. For each conversion the controller holds the sample line high for an acquisition window and then drops it. It waits a guard interval and sends exactly seventeen clock pulses. The result comes back MSB first. A bit is taken on each falling edge of pulses two to seventeen. The block then presents the 16-bit two's-complement word with a one-cycle strobe.

All timing is counted in cycles of the system clock. The parameters set the acquisition length, the guard delay, the clock high and low widths, the minimum low time of the sample line and the calibration pulse width. Elaboration rejects a clock period that is not longer than 480 ns. A start pulse launches one conversion. While the continuous input is held high, each frame chains into the next: the sample line rises together with the seventeenth clock pulse, so the next acquisition overlaps the end of the current conversion. A calibration request sends one high pulse on the calibration line. The controller then waits for the converter's busy flag to drop before it begins any conversion. A start or calibration request that arrives while the controller is occupied is remembered and served afterwards.

Top module: `adc_cap_ctrl`

## Requirements
- R1: After reset, `sample_o`, `cclk_o`, `cal_o` and `valid_o` are low and `data_o` is zero.
- R2: A conversion started from idle holds `sample_o` high for exactly ACQ_CYC clocks, with `cclk_o` low for that whole window.
- R3: The first rising edge of `cclk_o` comes exactly GUARD_CYC clocks after `sample_o` falls. No pulse is issued earlier.
- R4: Each conversion issues exactly 17 pulses on `cclk_o`. Each pulse is high for HI_CYC clocks and low for LO_CYC clocks. Elaboration fails unless (HI_CYC+LO_CYC)*CLK_NS exceeds MIN_PER_NS (480 ns by default).
- R5: `sdata_i` is sampled at the falling edges of pulses 2 to 17. The bit at pulse 2 is bit 15 (the MSB) and the bit at pulse 17 is bit 0. `data_o` is that word, read as two's complement.
- R6: `valid_o` is high for exactly one clock per conversion, on the clock where the 17th pulse falls. A result never carries bits from two frames.
- R7: When `cont_i` is high as the 17th pulse begins, `sample_o` rises on the same clock as that pulse. It stays high for ACQ_CYC clocks in total, and then the next frame follows without a further start.
- R8: Without `cont_i` and with no start pending, `sample_o` and `cclk_o` stay low after the 17th pulse. No further pulse is issued.
- R9: A start that arrives during a conversion is held. `sample_o` then rises LO_CYC clocks after the 17th pulse falls.
- R10: A calibration request drives `cal_o` high for CAL_CYC clocks. No acquisition starts until `busy_i` has dropped after that pulse, and a start that arrives meanwhile is served afterwards.
- R11: Once `sample_o` has fallen, it stays low for at least SLOW_CYC clocks before it rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion (pulse) |
| cont_i | input | 1 | Chain conversions while high |
| cal_req_i | input | 1 | Request a calibration pulse |
| busy_i | input | 1 | Busy flag from the converter |
| sdata_i | input | 1 | Serial data from the converter |
| sample_o | output | 1 | Sample-control line to the converter |
| cclk_o | output | 1 | Conversion clock to the converter |
| cal_o | output | 1 | Calibration line to the converter |
| data_o | output | 16 | Last captured word, two's complement |
| valid_o | output | 1 | One-cycle strobe for a new word in data_o |

## Verification
Most state errors show up on the pins within one clock-line phase. A wrong pulse counter either ends a frame at a count other than seventeen, or lets the sample line rise before the seventeenth pulse; both are visible at the next falling edge of the sample line. An off-by-one in a phase timer changes a measured high, low, guard or acquisition width by whole cycles. A bit counter in the capture path that is out of step with the framing shows up as a rotated or shifted word at the first strobe after the fault. A lost pending flag shows up as a missing conversion: the expected-result queue still holds items when the sequence ends.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAL,
        ST_CALW,
        ST_ACQ,
        ST_GUARD,
        ST_HI,
        ST_LO
    } cap_st_e;

    function automatic int max_of2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_cap_shift.sv
module adc_cap_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              cap_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int NW = $clog2(DATA_W);
    localparam logic [NW-1:0] LAST = NW'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [NW-1:0]     cnt;
        logic [DATA_W-1:0] data;
        logic              valid;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d = q;
        d.valid = 1'b0;
        if (clr_i) begin
            d.cnt = '0;
        end else if (cap_i) begin
            d.sh  = {q.sh[DATA_W-2:0], bit_i};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.data  = {q.sh[DATA_W-2:0], bit_i};
                d.valid = 1'b1;
                d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;

    AST_ONE_SHOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6
    AST_VALID_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(cap_i)); // R5

endmodule

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
    import adc_cap_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CLK_NS     = 4,
    parameter int MIN_PER_NS = 480,
    parameter int ACQ_CYC    = 150,
    parameter int GUARD_CYC  = 4,
    parameter int HI_CYC     = 61,
    parameter int LO_CYC     = 61,
    parameter int SLOW_CYC   = 200,
    parameter int CAL_CYC    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic              cal_req_i,
    input  logic              busy_i,
    input  logic              sdata_i,
    output logic              sample_o,
    output logic              cclk_o,
    output logic              cal_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int NPULSE = DATA_W + 1;
    localparam int PW     = $clog2(NPULSE + 1);
    localparam int MAXC   = max_of2(max_of2(max_of2(ACQ_CYC, GUARD_CYC), max_of2(HI_CYC, LO_CYC)),
                                    max_of2(SLOW_CYC, CAL_CYC));
    localparam int CW     = $clog2(MAXC + 2);

    localparam logic [CW-1:0] ACQ_LAST = CW'(ACQ_CYC - 1);
    localparam logic [CW-1:0] GRD_LAST = CW'(GUARD_CYC - 1);
    localparam logic [CW-1:0] HI_LAST  = CW'(HI_CYC - 1);
    localparam logic [CW-1:0] LO_LAST  = CW'(LO_CYC - 1);
    localparam logic [CW-1:0] CAL_LAST = CW'(CAL_CYC - 1);
    localparam logic [PW-1:0] P_LAST   = PW'(NPULSE);
    localparam logic [PW-1:0] P_CAP0   = PW'(2);

    generate
        if ((HI_CYC + LO_CYC) * CLK_NS <= MIN_PER_NS) begin : g_bad_period
            $error("conversion clock period too short");
        end
        if (GUARD_CYC + (NPULSE - 1) * (HI_CYC + LO_CYC) < SLOW_CYC) begin : g_bad_low
            $error("sample low time cannot be met");
        end
    endgenerate

    typedef struct packed {
        cap_st_e       st;
        logic [CW-1:0] tmr;
        logic [CW-1:0] acq;
        logic [PW-1:0] pcnt;
        logic          sample;
        logic          cclk;
        logic          cal;
        logic          pend_start;
        logic          pend_cal;
    } ctl_t;

    ctl_t q, d;
    logic cap_s, clr_s;

    always_comb begin
        d     = q;
        cap_s = 1'b0;
        clr_s = 1'b0;
        d.tmr = q.tmr + 1'b1;
        d.acq = !q.sample ? '0 : ((q.acq == '1) ? q.acq : q.acq + 1'b1);
        if (q.st != ST_IDLE && start_i)   d.pend_start = 1'b1;
        if (q.st != ST_IDLE && cal_req_i) d.pend_cal   = 1'b1;
        unique case (q.st)
            ST_IDLE: begin
                if (cal_req_i || q.pend_cal) begin
                    d.st = ST_CAL; d.cal = 1'b1; d.tmr = '0; d.pend_cal = 1'b0;
                end else if (start_i || q.pend_start) begin
                    d.st = ST_ACQ; d.sample = 1'b1; d.pend_start = 1'b0;
                end
            end
            ST_CAL: begin
                if (q.tmr == CAL_LAST) begin
                    d.st = ST_CALW; d.cal = 1'b0;
                end
            end
            ST_CALW: begin
                if (!busy_i) d.st = ST_IDLE;
            end
            ST_ACQ: begin
                if (q.acq >= ACQ_LAST) begin
                    d.st = ST_GUARD; d.sample = 1'b0; d.tmr = '0;
                end
            end
            ST_GUARD: begin
                if (q.tmr == GRD_LAST) begin
                    d.st = ST_HI; d.cclk = 1'b1; d.tmr = '0; d.pcnt = PW'(1);
                    clr_s = 1'b1;
                end
            end
            ST_HI: begin
                if (q.tmr == HI_LAST) begin
                    d.st = ST_LO; d.cclk = 1'b0; d.tmr = '0;
                    cap_s = (q.pcnt >= P_CAP0);
                end
            end
            ST_LO: begin
                if (q.tmr == LO_LAST) begin
                    d.tmr = '0;
                    if (q.pcnt != P_LAST) begin
                        d.st = ST_HI; d.cclk = 1'b1; d.pcnt = q.pcnt + 1'b1;
                        if (q.pcnt + 1'b1 == P_LAST && cont_i) begin
                            d.sample = 1'b1; d.pend_start = 1'b0;
                        end
                    end else if (q.sample) begin
                        if (q.acq >= ACQ_LAST) begin
                            d.st = ST_GUARD; d.sample = 1'b0;
                        end else begin
                            d.st = ST_ACQ;
                        end
                    end else if (q.pend_cal) begin
                        d.st = ST_CAL; d.cal = 1'b1; d.pend_cal = 1'b0;
                    end else if (start_i || q.pend_start) begin
                        d.st = ST_ACQ; d.sample = 1'b1; d.pend_start = 1'b0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sample_o = q.sample;
    assign cclk_o   = q.cclk;
    assign cal_o    = q.cal;

    adc_cap_shift #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_s),
        .cap_i   (cap_s),
        .bit_i   (sdata_i),
        .data_o  (data_o),
        .valid_o (valid_o)
    );

    // Checker-side counters, observed only by the assertions below.
    logic [CW-1:0] low_q;
    logic [PW-1:0] rises_q;
    logic          prev_s_q, prev_c_q, had_fall_q;
    logic          fall_now, rise_now;

    assign fall_now = prev_s_q && !sample_o;
    assign rise_now = !prev_c_q && cclk_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0; rises_q <= '0; prev_s_q <= 1'b0; prev_c_q <= 1'b0; had_fall_q <= 1'b0;
        end else begin
            prev_s_q   <= sample_o;
            prev_c_q   <= cclk_o;
            low_q      <= sample_o ? '0 : ((low_q == '1) ? low_q : low_q + 1'b1);
            rises_q    <= fall_now ? '0 : rises_q + PW'(rise_now);
            had_fall_q <= had_fall_q | fall_now;
        end
    end

    AST_CLK_QUIET_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && cclk_o) |-> (q.pcnt == P_LAST)); // R2
    AST_GUARD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cclk_o) && q.pcnt == PW'(1)) |-> (low_q >= CW'(GUARD_CYC))); // R3
    AST_SEVENTEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sample_o) && had_fall_q) |-> (rises_q == P_LAST)); // R4
    AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sample_o) && had_fall_q) |-> (low_q >= CW'(SLOW_CYC))); // R11
    AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CALW && busy_i) |=> !sample_o); // R10
    AST_CAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        cal_o |-> (!sample_o && !cclk_o)); // R10

endmodule

// File: tb/adc_cap_ctrl_bench.sv
module adc_cap_ctrl_bench;
    localparam int ACQ = 150, GRD = 4, HI = 61, LO = 61, SLOW = 200, CALW = 16, CALB = 300;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, cont_i = 1'b0, cal_req_i = 1'b0;
    logic busy_cv = 1'b0, busy_cal = 1'b0, sdata_i = 1'b0;
    logic busy_i;
    logic sample_o, cclk_o, cal_o, valid_o;
    logic [15:0] data_o;

    assign busy_i = busy_cv | busy_cal;
    always #2 clk = ~clk;

    adc_cap_ctrl #(.DATA_W(16), .CLK_NS(4), .MIN_PER_NS(480), .ACQ_CYC(ACQ),
                   .GUARD_CYC(GRD), .HI_CYC(HI), .LO_CYC(LO), .SLOW_CYC(SLOW),
                   .CAL_CYC(CALW)) u_adc_cap_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .cal_req_i(cal_req_i), .busy_i(busy_i), .sdata_i(sdata_i),
        .sample_o(sample_o), .cclk_o(cclk_o), .cal_o(cal_o),
        .data_o(data_o), .valid_o(valid_o));

    int total = 0, bad = 0, cyc = 0, nres = 0, pulses = 0;
    int t_sr = 0, t_sf = 0, t_cr = 0, t_cf = 0, t_calr = 0;
    bit p_s = 0, p_c = 0, p_v = 0, p_cal = 0, p_busy = 0;
    bit acq_bad = 0, had_fall = 0, in_cal = 0, cal_bad = 0, expect_pend = 0, done = 0;
    logic [15:0] mq[$];
    logic [15:0] eq[$];
    logic [15:0] cur = '0;
    int k = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: one expected item per conversion, given to model and scoreboard
    task automatic push_word(input logic [15:0] w);
        mq.push_back(w);
        eq.push_back(w);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic wait_res(input int n);
        while (nres < n) @(posedge clk);
    endtask

    // behavioural converter pins
    always @(negedge sample_o) if (rst_n) begin
        cur = (mq.size() != 0) ? mq.pop_front() : 16'h0000;
        busy_cv = 1'b1;
        k = 0;
    end
    always @(posedge cclk_o) if (busy_cv) begin
        k++;
        if (k >= 2) sdata_i = cur[17-k];
        if (k == 17) busy_cv = 1'b0;
    end
    always @(posedge cal_o) busy_cal = 1'b1;
    always @(negedge cal_o) if (rst_n) begin
        repeat (CALB) @(posedge clk);
        busy_cal <= 1'b0;
    end

    always @(posedge clk) cyc <= cyc + 1;

    // monitor / scoreboard
    always @(negedge clk) if (rst_n) begin
        if (cclk_o && !p_c) begin
            pulses++;
            if (pulses == 1) chk(cyc - t_sf == GRD, "R3 guard", cyc - t_sf, GRD);
            else             chk(cyc - t_cf == LO, "R4 low width", cyc - t_cf, LO);
            t_cr = cyc;
        end
        if (!cclk_o && p_c) begin
            chk(cyc - t_cr == HI, "R4 high width", cyc - t_cr, HI);
            t_cf = cyc;
        end
        if (sample_o && !p_s) begin
            if (in_cal) cal_bad = 1;
            if (had_fall) chk(cyc - t_sf >= SLOW, "R11 min low", cyc - t_sf, SLOW);
            if (cclk_o) chk(pulses == 17, "R7 rise with 17th pulse", pulses, 17);
            else if (expect_pend) begin
                chk(cyc - t_cf == LO, "R9 pending start", cyc - t_cf, LO);
                expect_pend = 0;
            end
            t_sr = cyc;
            acq_bad = 0;
        end
        if (sample_o && cclk_o && pulses != 17) acq_bad = 1;
        if (!sample_o && p_s) begin
            chk(cyc - t_sr == ACQ, "R2/R7 acquisition width", cyc - t_sr, ACQ);
            chk(!acq_bad, "R2 clock quiet in acquisition", acq_bad, 0);
            pulses = 0;
            t_sf = cyc;
            had_fall = 1;
        end
        if (valid_o) begin
            chk(!p_v, "R6 single-cycle strobe", p_v, 0);
            chk(pulses == 17 && !cclk_o, "R4/R6 strobe at 17th fall", pulses, 17);
            if (eq.size() == 0) chk(0, "R5 unexpected result", data_o, -1);
            else begin
                logic [15:0] e;
                e = eq.pop_front();
                chk(data_o == e, "R5 data word", $signed(data_o), $signed(e));
            end
            nres++;
        end
        if (cal_o && !p_cal) begin
            t_calr = cyc; in_cal = 1; cal_bad = 0;
        end
        if (!cal_o && p_cal) chk(cyc - t_calr == CALW, "R10 cal width", cyc - t_calr, CALW);
        if (!busy_i && p_busy && in_cal) begin
            in_cal = 0;
            chk(!cal_bad, "R10 no sample before busy drops", cal_bad, 0);
        end
        p_s = sample_o; p_c = cclk_o; p_v = valid_o; p_cal = cal_o; p_busy = busy_i;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(sample_o == 0 && cclk_o == 0 && cal_o == 0, "R1 lines low", {sample_o, cclk_o, cal_o}, 0);
        chk(valid_o == 0 && data_o == 0, "R1 result clear", data_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sample_o == 0 && cclk_o == 0, "R1 idle after reset", sample_o, 0);

        // R10: calibration with a start arriving meanwhile
        push_word(16'h1357);
        pulse(cal_req_i);
        repeat (5) @(negedge clk);
        pulse(start_i);
        wait_res(1);

        // R2 R5: single conversions, extreme codes
        push_word(16'h7FFF);
        pulse(start_i);
        wait_res(2);
        repeat (SLOW) @(negedge clk);
        push_word(16'h8000);
        pulse(start_i);
        wait_res(3);
        repeat (300) @(negedge clk);
        chk(sample_o == 0 && cclk_o == 0, "R8 idle after single", {sample_o, cclk_o}, 0);
        chk(pulses == 17, "R8 no extra pulses", pulses, 17);

        // R9: start during a conversion is held
        push_word(16'h00FF);
        push_word(16'hFF00);
        pulse(start_i);
        repeat (600) @(negedge clk);
        expect_pend = 1;
        pulse(start_i);
        wait_res(5);
        chk(expect_pend == 0, "R9 pending start serviced", expect_pend, 0);
        repeat (300) @(negedge clk);

        // R7: continuous chaining, four frames
        push_word(16'h0000);
        push_word(16'hFFFF);
        push_word(16'h1234);
        push_word(16'hEDCB);
        @(negedge clk) cont_i = 1'b1;
        pulse(start_i);
        wait_res(8);
        @(negedge clk) cont_i = 1'b0;
        wait_res(9);
        repeat (400) @(negedge clk);
        chk(sample_o == 0 && cclk_o == 0, "R8 stop after continuous", {sample_o, cclk_o}, 0);
        chk(eq.size() == 0, "R5 all results seen", eq.size(), 0);
        chk(nres == 9, "R7 frame count", nres, 9);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", nres, 9);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule